// File: doc/BRIEF.md
# Buck Regulator Output Code Ramp Controller

This block is the digital control for one step-down regulator channel. It keeps a programmed 7-bit voltage code and drives a registered output code toward it. Each code step stands for 6.25 mV above a 700 mV floor, so code `c` asks for `700 + 6.25*c` mV. Upward and downward moves are governed separately. Each direction has its own enable bit, its own transition bit and its own rate field. When a direction may ramp, the output moves one code at a time, with a programmable wait between steps. When a direction may not ramp, the output jumps to the target in one cycle.

A hardware sleep path can swap in a separate sleep code as the target. This happens while the sleep request input is high, but only if sleep control is enabled. With sleep control enabled, the awake target comes from the hardware-controlled copy of the target register. Otherwise it comes from the normal copy. Software is expected to keep both copies equal. A settled flag reports when the output has reached the target now in force.

Top module: `buck_ramp_ctrl`

## Requirements
- R1: After reset the output code is 0, every register field is 0 and `settled` is 1.
- R2: A write with `wrEn` high stores `wrData` at `wrAddr` on the clock edge. The address map is: 0 = normal target code [6:0]; 1 = hardware target code [6:0]; 2 = sleep code [6:0]; 3 = rise rate [6:0] with rise enable at bit 7; 4 = fall rate [6:0] with fall enable at bit 7; 5 = mode, with sleep control at bit 0, rising transition at bit 1 and falling transition at bit 2.
- R3: When the target is above the output and both rise enable and the rising transition bit are set, the output steps up by exactly one code every `PRESCALE*(riseRate+1)` cycles. The first step comes that many cycles after the edge that changed the target.
- R4: When the target is below the output and both fall enable and the falling transition bit are set, the output steps down by exactly one code every `PRESCALE*(fallRate+1)` cycles.
- R5: When the enable or the transition bit for the needed direction is clear, the output equals the target one clock edge after the target changes.
- R6: `settled` is 1 exactly when the output code equals the target now in force. While it is 1 and no input changes, the output holds.
- R7: With sleep control set and `sleepReq` high, the target in force is the sleep code. With sleep control clear, `sleepReq` has no effect on the output.
- R8: With sleep control set, the awake target is the hardware target code and the normal code is ignored. With sleep control clear, the normal code is the target and the hardware code is ignored.
- R9: A target changed during a ramp takes effect from the present output code. The ramp reverses direction from there, without restarting from the old target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| sleepReq | input | 1 | Hardware sleep request |
| outCode | output | 7 | Present output voltage code |
| settled | output | 1 | Output equals the target in force |

## Verification
A stuck or mis-selected target shows at `outCode` one edge after a write in jump mode. A miscounting prescaler or rate counter shows as a wrong interval between successive output changes, visible within one step period. A wrong direction or step size shows as an output value off by more than one code after the first step. The benches also re-target mid-ramp to expose a controller that restarts from a stale code instead of the present one.

// File: rtl/buck_ramp_pkg.sv
package buck_ramp_pkg;
  // register addresses
  localparam logic [2:0] ADDR_TGT_NORM = 3'd0;
  localparam logic [2:0] ADDR_TGT_HW   = 3'd1;
  localparam logic [2:0] ADDR_SLEEP    = 3'd2;
  localparam logic [2:0] ADDR_RISE     = 3'd3;
  localparam logic [2:0] ADDR_FALL     = 3'd4;
  localparam logic [2:0] ADDR_MODE     = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic jump;
    logic stepUp;
    logic stepDown;
  } rampCmd_t;
endpackage

// File: rtl/buck_ramp_regs.sv
module buck_ramp_regs #(
  parameter int CODE_W = 7,
  parameter int RATE_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [CODE_W-1:0] tgtNorm,
  output logic [CODE_W-1:0] tgtHw,
  output logic [CODE_W-1:0] sleepCode,
  output logic [RATE_W-1:0] riseRate,
  output logic [RATE_W-1:0] fallRate,
  output logic              riseEn,
  output logic              fallEn,
  output logic              sleepEn,
  output logic              transRise,
  output logic              transFall
);
  import buck_ramp_pkg::*;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtNorm   <= '0;
      tgtHw     <= '0;
      sleepCode <= '0;
      riseRate  <= '0;
      fallRate  <= '0;
      riseEn    <= 1'b0;
      fallEn    <= 1'b0;
      sleepEn   <= 1'b0;
      transRise <= 1'b0;
      transFall <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_TGT_NORM: tgtNorm   <= wrData[CODE_W-1:0];
        ADDR_TGT_HW:   tgtHw     <= wrData[CODE_W-1:0];
        ADDR_SLEEP:    sleepCode <= wrData[CODE_W-1:0];
        ADDR_RISE: begin
          riseRate <= wrData[RATE_W-1:0];
          riseEn   <= wrData[DATA_W-1];
        end
        ADDR_FALL: begin
          fallRate <= wrData[RATE_W-1:0];
          fallEn   <= wrData[DATA_W-1];
        end
        ADDR_MODE: begin
          sleepEn   <= wrData[0];
          transRise <= wrData[1];
          transFall <= wrData[2];
        end
        default: ;
      endcase
    end
  end

  assert_tgt_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_TGT_NORM) |=> tgtNorm == $past(wrData[CODE_W-1:0]));
endmodule

// File: rtl/buck_ramp_ctrl_fsm.sv
module buck_ramp_ctrl_fsm #(
  parameter int CODE_W   = 7,
  parameter int RATE_W   = 7,
  parameter int PRESCALE = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CODE_W-1:0]         tgtNorm,
  input  logic [CODE_W-1:0]         tgtHw,
  input  logic [CODE_W-1:0]         sleepCode,
  input  logic [RATE_W-1:0]         riseRate,
  input  logic [RATE_W-1:0]         fallRate,
  input  logic                      riseEn,
  input  logic                      fallEn,
  input  logic                      sleepEn,
  input  logic                      transRise,
  input  logic                      transFall,
  input  logic                      sleepReq,
  input  logic [CODE_W-1:0]         outCode,
  output logic [CODE_W-1:0]         activeTgt,
  output buck_ramp_pkg::rampCmd_t   cmd,
  output logic                      settled
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [RATE_W-1:0] rateCnt;
  logic              busy, goUp, rampOn, tick, stepNow;
  logic [RATE_W-1:0] curRate;

  always_comb begin
    if (sleepEn) activeTgt = sleepReq ? sleepCode : tgtHw;
    else         activeTgt = tgtNorm;
    busy    = (outCode != activeTgt);
    goUp    = (activeTgt > outCode);
    rampOn  = goUp ? (riseEn && transRise) : (fallEn && transFall);
    curRate = goUp ? riseRate : fallRate;
    tick    = (preCnt == PRE_LAST);
    stepNow = busy && rampOn && tick && (rateCnt >= curRate);
    cmd.jump     = busy && !rampOn;
    cmd.stepUp   = stepNow && goUp;
    cmd.stepDown = stepNow && !goUp;
    settled  = !busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      rateCnt <= '0;
    end else if (!busy || !rampOn || stepNow) begin
      preCnt  <= '0;
      rateCnt <= '0;
    end else if (tick) begin
      preCnt  <= '0;
      rateCnt <= rateCnt + 1'b1;
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.jump, cmd.stepUp, cmd.stepDown}));
endmodule

// File: rtl/buck_ramp_datapath.sv
module buck_ramp_datapath #(
  parameter int CODE_W = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  buck_ramp_pkg::rampCmd_t cmd,
  input  logic [CODE_W-1:0]       target,
  output logic [CODE_W-1:0]       outCode
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outCode <= '0;
    else if (cmd.jump)     outCode <= target;
    else if (cmd.stepUp)   outCode <= outCode + 1'b1;
    else if (cmd.stepDown) outCode <= outCode - 1'b1;
  end

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.jump |=> (outCode == $past(outCode)
                   || outCode == CODE_W'($past(outCode) + 1'b1)
                   || outCode == CODE_W'($past(outCode) - 1'b1)));

  assert_jump_lands_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.jump |=> outCode == $past(target));
endmodule

// File: rtl/buck_ramp_ctrl.sv
module buck_ramp_ctrl #(
  parameter int CODE_W   = 7,
  parameter int RATE_W   = 7,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic              sleepReq,
  output logic [CODE_W-1:0] outCode,
  output logic              settled
);
  localparam int DATA_W = 8;

  logic [CODE_W-1:0] tgtNorm, tgtHw, sleepCode, activeTgt;
  logic [RATE_W-1:0] riseRate, fallRate;
  logic riseEn, fallEn, sleepEn, transRise, transFall;
  buck_ramp_pkg::rampCmd_t cmd;

  buck_ramp_regs #(.CODE_W(CODE_W), .RATE_W(RATE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tgtNorm(tgtNorm), .tgtHw(tgtHw), .sleepCode(sleepCode),
    .riseRate(riseRate), .fallRate(fallRate), .riseEn(riseEn), .fallEn(fallEn),
    .sleepEn(sleepEn), .transRise(transRise), .transFall(transFall));

  buck_ramp_ctrl_fsm #(.CODE_W(CODE_W), .RATE_W(RATE_W), .PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tgtNorm(tgtNorm), .tgtHw(tgtHw), .sleepCode(sleepCode),
    .riseRate(riseRate), .fallRate(fallRate), .riseEn(riseEn), .fallEn(fallEn),
    .sleepEn(sleepEn), .transRise(transRise), .transFall(transFall),
    .sleepReq(sleepReq), .outCode(outCode), .activeTgt(activeTgt),
    .cmd(cmd), .settled(settled));

  buck_ramp_datapath #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .target(activeTgt), .outCode(outCode));

  assert_settled_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !wrEn && $stable(sleepReq)) |=> $stable(outCode));
endmodule

// File: tb/buck_ramp_ctrl_tb.sv
module buck_ramp_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       sleepReq = 1'b0;
  logic [6:0] outCode;
  logic       settled;
  int checks = 0;
  int errors = 0;
  int n;

  localparam int P = 4;

  buck_ramp_ctrl #(.CODE_W(7), .RATE_W(7), .PRESCALE(P)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sleepReq(sleepReq), .outCode(outCode), .settled(settled));

  always #4 clk = ~clk;

  // {addr, data, expected out, expected settled}; all ramps disabled
  localparam logic [18:0] VEC [8] = '{
    {3'd0, 8'h20, 7'h20, 1'b1},  // R5 jump up
    {3'd0, 8'h05, 7'h05, 1'b1},  // R5 jump down
    {3'd1, 8'h40, 7'h05, 1'b1},  // R8 hw code ignored, sleep ctrl off
    {3'd5, 8'h01, 7'h40, 1'b1},  // R8 sleep ctrl on selects hw code
    {3'd2, 8'h18, 7'h40, 1'b1},  // R7 sleep code unused without request
    {3'd0, 8'h7F, 7'h40, 1'b1},  // R8 normal code ignored
    {3'd1, 8'h7F, 7'h7F, 1'b1},  // R8 hw code followed
    {3'd5, 8'h00, 7'h7F, 1'b1}   // R8 back to normal code
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic measure();
    logic [6:0] prev;
    prev = outCode;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      n++;
      if (outCode != prev) break;
    end
  endtask

  task automatic waitSettle();
    for (int i = 0; i < 2000; i++) begin
      if (settled) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out", outCode, 0);
    chk("R1 reset settled", settled, 1);
    rstN = 1'b1;

    for (int v = 0; v < 8; v++) begin
      wr(VEC[v][18:16], VEC[v][15:8]);
      @(negedge clk);
      chk($sformatf("R2/R5/R8 vector %0d out", v), outCode, VEC[v][7:1]);
      chk($sformatf("R6 vector %0d settled", v), settled, VEC[v][0]);
    end

    // R7: request ignored without sleep control
    sleepReq = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R7 request ignored", outCode, 7'h7F);
    wr(3'd5, 8'h01);
    @(negedge clk);
    chk("R7 sleep code in force", outCode, 7'h18);
    sleepReq = 1'b0;
    @(negedge clk);
    chk("R7 wake returns to hw code", outCode, 7'h7F);
    wr(3'd5, 8'h00);

    // ramps
    wr(3'd0, 8'h10);
    @(negedge clk);
    chk("R5 setup jump", outCode, 7'h10);
    wr(3'd3, 8'h82);
    wr(3'd4, 8'h80);
    wr(3'd5, 8'h06);
    wr(3'd0, 8'h14);
    measure();
    chk("R3 first rise interval", n, P * 3);
    chk("R3 first rise value", outCode, 7'h11);
    chk("R6 not settled mid ramp", settled, 0);
    measure();
    chk("R3 second rise interval", n, P * 3);
    chk("R3 second rise value", outCode, 7'h12);
    waitSettle();
    chk("R3 rise final", outCode, 7'h14);

    wr(3'd0, 8'h12);
    measure();
    chk("R4 fall interval", n, P);
    chk("R4 fall value", outCode, 7'h13);
    waitSettle();
    chk("R4 fall final", outCode, 7'h12);

    // R9: reverse mid ramp
    wr(3'd0, 8'h18);
    measure();
    chk("R9 rising step", outCode, 7'h13);
    wr(3'd0, 8'h10);
    measure();
    chk("R9 reverses from present code", outCode, 7'h12);
    waitSettle();
    chk("R9 final", outCode, 7'h10);

    // R5: rising transition bit cleared
    wr(3'd5, 8'h04);
    wr(3'd0, 8'h30);
    @(negedge clk);
    chk("R5 jump with rise transition off", outCode, 7'h30);
    wr(3'd0, 8'h2E);
    measure();
    chk("R4 fall still ramps", outCode, 7'h2F);
    waitSettle();

    // R5: rise enable cleared
    wr(3'd5, 8'h06);
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h40);
    @(negedge clk);
    chk("R5 jump with rise enable off", outCode, 7'h40);
    chk("R6 settled after jump", settled, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule